// File: doc/BRIEF.md
# Ethernet Receive Frame Buffer

This block holds one received Ethernet frame in on-chip RAM and makes it available to a host through a word-addressed read port. Frame bytes arrive one per cycle on a byte-stream input. The final byte carries an end marker, and the CRC-valid and length-legal verdicts from the MAC travel with that byte. The MAC computes the CRC. This block only uses the verdict.

When a frame passes the acceptance filter, the block publishes three things at once:
- a status word,
- a length word,
- the packed frame bytes, with the first byte of each pair in the low half of the word.

The four trailing CRC bytes are kept or dropped according to a configuration bit. Each accepted frame marks a receive event, and can raise an interrupt. The host reads and clears the event through an event-queue read. Frames that are not accepted leave everything the host can see untouched.

Top module: `eth_rx_frame_buf`

## Requirements
- R1: The host read port is byte-addressed, and only word-aligned addresses are mapped. The status word is at 0x0400, the length word at 0x0402, and frame data starts at 0x0404. The value of a read issued on a cycle with `host_rd` high appears on `host_rdata` in the next cycle. Odd or unmapped addresses read 0x0000. Frame bytes at an index at or beyond the reported length read as 0x00.
- R2: Byte `2k` of a frame is the low byte (bits 7:0) of the word at 0x0404+2k. Byte `2k+1` is the high byte (bits 15:8) of that word.
- R3: With `cfg_keep_crc`=1, the length word counts every received byte, including the 4 CRC bytes, and those bytes are readable as the last two data words. A 64-byte frame therefore reports length 0x0040 and is read with 32 word reads from 0x0404 to 0x0442.
- R4: With `cfg_keep_crc`=0, the length word equals the received byte count minus 4, and the CRC bytes read as zero.
- R5: A frame is good when both `rx_crc_ok` and `rx_len_ok` are 1 on its last byte. A good frame is accepted only while `cfg_accept_ok`=1. Accepting a frame writes status word 0x0104 (bit 8 = good frame, bits 5:0 = event code 0x04).
- R6: A frame is rejected in any of these cases:
  - it is not good;
  - it arrives while `cfg_accept_ok`=0;
  - it exceeds MAX_BYTES;
  - it has fewer than 4 bytes.

  A rejected frame leaves the status word, the length word and the previously published data unchanged. It raises no interrupt and no event.
- R7: When a frame is accepted with `cfg_irq_en`=1, `irq` rises in the following cycle and stays high until an event-queue read. With `cfg_irq_en`=0, `irq` stays low but the event is still queued.
- R8: A pulse on `isq_rd` puts 0x0104 on `isq_data` in the next cycle if an event is pending, and 0x0000 otherwise. The same pulse clears the pending event and `irq`.
- R9: An event-queue read and the acceptance of a new frame can fall in the same cycle. The queue read then returns the state from before the new frame, and the new event stays pending with `irq` set if enabled. A host read in that cycle likewise returns the previous length.
- R10: After reset, `irq` is 0, and the status word, the length word and `isq_data` are 0x0000. `rx_crc_ok` and `rx_len_ok` are ignored on every byte except the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_crc_ok | input | 1 | CRC verdict, sampled with the last byte |
| rx_len_ok | input | 1 | Length verdict, sampled with the last byte |
| cfg_keep_crc | input | 1 | Keep the 4 CRC bytes and count them in the length |
| cfg_accept_ok | input | 1 | Accept good frames |
| cfg_irq_en | input | 1 | Raise an interrupt on each accepted frame |
| host_rd | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host byte address |
| host_rdata | output | 16 | Host read data, one cycle after the request |
| isq_rd | input | 1 | Event-queue read pulse |
| isq_data | output | 16 | Event word returned by the last queue read |
| irq | output | 1 | Receive interrupt |

## Verification
Two coincidences are provoked, both on the cycle in which the final byte of a good frame is committed:
- A queue read, which collides with the setting of the pending event and the interrupt.
- A host read of the length word, which collides with the update of that word.

The bench places both pulses on the same clock edge as the last byte, once with an event already pending and once with none. It then judges three things:
- the returned event word and length must describe the state before the frame;
- `irq` must remain high afterwards;
- a second queue read must still return the new event.

// File: rtl/rxbuf_pkg.sv
// Package: shared constants and types of the receive frame buffer.
// Assumes host addresses are at most 16 bits wide.
package rxbuf_pkg;
    localparam int unsigned CRC_BYTES  = 4;
    localparam int unsigned OFS_STATUS = 'h400;
    localparam int unsigned OFS_LENGTH = 'h402;
    localparam int unsigned OFS_DATA   = 'h404;

    // Event word: bit 8 = good frame, bits 5:0 = receive event code
    localparam logic [15:0] EVT_GOOD = 16'h0104;
    localparam logic [15:0] EVT_NONE = 16'h0000;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_REG    = 2'd1,
        SEL_DATA   = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/rxbuf_writer.sv
// Module: rxbuf_writer
// Counts incoming frame bytes, produces RAM byte writes into the fill bank
// and decides at the last byte whether the frame is committed.
// Assumes the verdict flags are meaningful only together with rx_last.
module rxbuf_writer
    import rxbuf_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 1518,
    parameter int unsigned CNT_W     = 11,
    parameter int unsigned AW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_ok,
    input  logic          rx_len_ok,
    input  logic          cfg_keep_crc,
    input  logic          cfg_accept_ok,
    output logic          wr_en,
    output logic [AW-1:0] wr_word,
    output logic          wr_hi,
    output logic [7:0]    wr_byte,
    output logic          commit,
    output logic [15:0]   commit_len
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             room;
    logic [15:0]      total;
    logic             too_long;
    logic             good;

    // Byte placement and commit decision for the current input byte
    always_comb begin
        room       = (cnt_q < CNT_W'(MAX_BYTES));
        wr_en      = rx_valid && room;
        wr_word    = AW'(cnt_q >> 1);
        wr_hi      = cnt_q[0];
        wr_byte    = rx_data;
        total      = 16'(cnt_q) + 16'd1;
        too_long   = ovf_q || !room;
        good       = rx_crc_ok && rx_len_ok && !too_long
                     && (total >= 16'(CRC_BYTES));
        commit     = rx_valid && rx_last && good && cfg_accept_ok;
        commit_len = cfg_keep_crc ? total : (total - 16'(CRC_BYTES));
    end

    // Byte counter and overflow flag, both restarted after each frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (rx_valid) begin
            if (rx_last) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (room) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                ovf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxbuf_ram.sv
// Module: rxbuf_ram
// Two-bank frame store split into low and high byte lanes, one write port
// (byte granular) and one synchronous 16-bit read port.
// Assumes writer and reader always address different banks.
module rxbuf_ram #(
    parameter int unsigned DEPTH = 759,
    parameter int unsigned AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_word,
    input  logic          wr_hi,
    input  logic [7:0]    wr_byte,
    input  logic          rd_en,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_word,
    output logic [15:0]   rd_q
);
    localparam int unsigned IW    = AW + 1;
    localparam int unsigned SLOTS = 2 * DEPTH;

    logic [IW-1:0] widx;
    logic [IW-1:0] ridx;

    // Flatten bank and word into one lane index
    always_comb begin
        widx = wr_bank ? (IW'(DEPTH) + IW'(wr_word)) : IW'(wr_word);
        ridx = rd_bank ? (IW'(DEPTH) + IW'(rd_word)) : IW'(rd_word);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] mem [SLOTS];

        // Lane write: stores the byte whose position parity matches this lane
        always_ff @(posedge clk) begin
            if (wr_en && (wr_hi == g[0])) begin
                mem[widx] <= wr_byte;
            end
        end

        // Lane read: registered output
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q[g*8 +: 8] <= 8'h00;
            end else if (rd_en) begin
                rd_q[g*8 +: 8] <= mem[ridx];
            end
        end
    end
endmodule

// File: rtl/rxbuf_state.sv
// Module: rxbuf_state
// Holds the published status and length words, the bank shown to the host,
// the pending receive event, the interrupt and the event-queue output.
// Assumes commit is a single-cycle pulse.
module rxbuf_state
    import rxbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic [15:0] commit_len,
    input  logic        cfg_irq_en,
    input  logic        isq_rd,
    output logic [15:0] status_q,
    output logic [15:0] length_q,
    output logic        rd_bank,
    output logic        pending,
    output logic        irq,
    output logic [15:0] isq_data
);
    // Publish a committed frame: new words and bank swap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= EVT_NONE;
            length_q <= 16'h0000;
            rd_bank  <= 1'b0;
        end else if (commit) begin
            status_q <= EVT_GOOD;
            length_q <= commit_len;
            rd_bank  <= ~rd_bank;
        end
    end

    // Event and interrupt: a new commit wins over a clearing queue read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (commit) begin
                pending <= 1'b1;
            end else if (isq_rd) begin
                pending <= 1'b0;
            end
            if (commit && cfg_irq_en) begin
                irq <= 1'b1;
            end else if (isq_rd) begin
                irq <= 1'b0;
            end
        end
    end

    // Queue read output reflects the event state before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isq_data <= EVT_NONE;
        end else if (isq_rd) begin
            isq_data <= pending ? EVT_GOOD : EVT_NONE;
        end
    end
endmodule

// File: rtl/rxbuf_hostport.sv
// Module: rxbuf_hostport
// Decodes host byte addresses into status, length or frame data, drives the
// RAM read and masks bytes at or beyond the published length.
// Assumes ADDR_W <= 16 and that the frame area fits below 2**ADDR_W.
module rxbuf_hostport
    import rxbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 759,
    parameter int unsigned AW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       status_q,
    input  logic [15:0]       length_q,
    input  logic [15:0]       ram_q,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_rd_word,
    output logic [15:0]       host_rdata
);
    logic [ADDR_W-1:0] byte_idx;
    logic [15:0]       idx16;
    logic              is_status;
    logic              is_length;
    logic              in_data;
    logic              lo_ok;
    logic              hi_ok;
    rd_sel_e           sel_d;
    rd_sel_e           sel_q;
    logic [15:0]       reg_q;
    logic              lo_ok_q;
    logic              hi_ok_q;

    // Address decode and per-byte validity against the current length
    always_comb begin
        byte_idx    = host_addr - ADDR_W'(OFS_DATA);
        idx16       = 16'(byte_idx);
        is_status   = (host_addr == ADDR_W'(OFS_STATUS));
        is_length   = (host_addr == ADDR_W'(OFS_LENGTH));
        in_data     = !host_addr[0]
                      && (host_addr >= ADDR_W'(OFS_DATA))
                      && (idx16 < 16'(2 * DEPTH));
        lo_ok       = idx16 < length_q;
        hi_ok       = (idx16 + 16'd1) < length_q;
        ram_rd_en   = host_rd && in_data;
        ram_rd_word = AW'(byte_idx >> 1);
        if (is_status || is_length) begin
            sel_d = SEL_REG;
        end else if (in_data) begin
            sel_d = SEL_DATA;
        end else begin
            sel_d = SEL_NONE;
        end
    end

    // Capture the selection and register snapshot of each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= SEL_NONE;
            reg_q   <= 16'h0000;
            lo_ok_q <= 1'b0;
            hi_ok_q <= 1'b0;
        end else if (host_rd) begin
            sel_q   <= sel_d;
            reg_q   <= is_status ? status_q : length_q;
            lo_ok_q <= lo_ok;
            hi_ok_q <= hi_ok;
        end
    end

    // Output mux from registered state
    always_comb begin
        case (sel_q)
            SEL_REG:  host_rdata = reg_q;
            SEL_DATA: host_rdata = {hi_ok_q ? ram_q[15:8] : 8'h00,
                                    lo_ok_q ? ram_q[7:0]  : 8'h00};
            default:  host_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/eth_rx_frame_buf.sv
// Module: eth_rx_frame_buf
// Top of the single-frame receive buffer: writer fills the hidden bank,
// a commit swaps banks and publishes status/length, the host port reads.
// Assumes MAX_BYTES is at least 4 and the map fits in ADDR_W bits.
module eth_rx_frame_buf
    import rxbuf_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 1518,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_crc_ok,
    input  logic              rx_len_ok,
    input  logic              cfg_keep_crc,
    input  logic              cfg_accept_ok,
    input  logic              cfg_irq_en,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [15:0]       host_rdata,
    input  logic              isq_rd,
    output logic [15:0]       isq_data,
    output logic              irq
);
    localparam int unsigned DEPTH = (MAX_BYTES + 1) / 2;
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

    logic          wr_en;
    logic [AW-1:0] wr_word;
    logic          wr_hi;
    logic [7:0]    wr_byte;
    logic          commit;
    logic [15:0]   commit_len;
    logic [15:0]   status_q;
    logic [15:0]   length_q;
    logic          rd_bank;
    logic          pending;
    logic          ram_rd_en;
    logic [AW-1:0] ram_rd_word;
    logic [15:0]   ram_q;

    rxbuf_writer #(
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W),
        .AW       (AW)
    ) writer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .rx_crc_ok    (rx_crc_ok),
        .rx_len_ok    (rx_len_ok),
        .cfg_keep_crc (cfg_keep_crc),
        .cfg_accept_ok(cfg_accept_ok),
        .wr_en        (wr_en),
        .wr_word      (wr_word),
        .wr_hi        (wr_hi),
        .wr_byte      (wr_byte),
        .commit       (commit),
        .commit_len   (commit_len)
    );

    rxbuf_ram #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) ram_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_bank(~rd_bank),
        .wr_word(wr_word),
        .wr_hi  (wr_hi),
        .wr_byte(wr_byte),
        .rd_en  (ram_rd_en),
        .rd_bank(rd_bank),
        .rd_word(ram_rd_word),
        .rd_q   (ram_q)
    );

    rxbuf_state state_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .commit_len(commit_len),
        .cfg_irq_en(cfg_irq_en),
        .isq_rd    (isq_rd),
        .status_q  (status_q),
        .length_q  (length_q),
        .rd_bank   (rd_bank),
        .pending   (pending),
        .irq       (irq),
        .isq_data  (isq_data)
    );

    rxbuf_hostport #(
        .ADDR_W(ADDR_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .status_q   (status_q),
        .length_q   (length_q),
        .ram_q      (ram_q),
        .ram_rd_en  (ram_rd_en),
        .ram_rd_word(ram_rd_word),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/eth_rx_frame_buf_chk.sv
// Module: eth_rx_frame_buf_chk
// Temporal checks on the event, interrupt and publish state of the buffer.
module eth_rx_frame_buf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic        pending,
    input logic        irq,
    input logic        isq_rd,
    input logic [15:0] isq_data,
    input logic        cfg_irq_en,
    input logic [15:0] status_q,
    input logic [15:0] length_q
);
    assert_irq_has_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(commit && cfg_irq_en));

    assert_queue_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isq_rd && !commit) |=> (!irq && !pending));

    assert_queue_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        isq_rd |=> (isq_data == ($past(pending) ? 16'h0104 : 16'h0000)));

    assert_commit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pending);

    assert_reject_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(length_q) && $stable(status_q)));

    assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 16'h0000) || (status_q == 16'h0104));
endmodule

bind eth_rx_frame_buf eth_rx_frame_buf_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .pending   (pending),
    .irq       (irq),
    .isq_rd    (isq_rd),
    .isq_data  (isq_data),
    .cfg_irq_en(cfg_irq_en),
    .status_q  (status_q),
    .length_q  (length_q)
);

// File: tb/eth_rx_frame_buf_tb_top.sv
// Directed bench for the receive frame buffer.
module eth_rx_frame_buf_tb_top;
    localparam int MAXB = 1518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_crc_ok = 1'b0;
    logic        rx_len_ok = 1'b0;
    logic        cfg_keep_crc = 1'b1;
    logic        cfg_accept_ok = 1'b1;
    logic        cfg_irq_en = 1'b1;
    logic        host_rd = 1'b0;
    logic [11:0] host_addr = 12'h000;
    logic [15:0] host_rdata;
    logic        isq_rd = 1'b0;
    logic [15:0] isq_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    eth_rx_frame_buf #(.MAX_BYTES(MAXB), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_ok(rx_crc_ok), .rx_len_ok(rx_len_ok),
        .cfg_keep_crc(cfg_keep_crc), .cfg_accept_ok(cfg_accept_ok),
        .cfg_irq_en(cfg_irq_en), .host_rd(host_rd), .host_addr(host_addr),
        .host_rdata(host_rdata), .isq_rd(isq_rd), .isq_data(isq_data), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed + i * 37 + (i >> 3));
    endfunction

    task automatic send_frame(input int n, input int seed, input bit crc, input bit lok,
                              input bit isq_last, input bit rd_last, input logic [11:0] ra);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_data   = pat(seed, i);
            rx_last   = (i == n - 1);
            // flags inverted on non-last bytes: they must be ignored (R10)
            rx_crc_ok = rx_last ? crc : ~crc;
            rx_len_ok = rx_last ? lok : ~lok;
            if (rx_last && isq_last) isq_rd = 1'b1;
            if (rx_last && rd_last) begin
                host_rd = 1'b1;
                host_addr = ra;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; isq_rd = 1'b0; host_rd = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic qread(output logic [15:0] d);
        @(negedge clk);
        isq_rd = 1'b1;
        @(negedge clk);
        isq_rd = 1'b0;
        d = isq_data;
    endtask

    task automatic check_frame(input string req, input int seed, input int len);
        logic [15:0] d;
        for (int w = 0; w < (len + 2) / 2; w++) begin
            hread(12'(12'h404 + 2 * w), d);
            chk(req, d, {(2 * w + 1 < len) ? pat(seed, 2 * w + 1) : 8'h00,
                         (2 * w < len) ? pat(seed, 2 * w) : 8'h00});
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R10 irq", {15'd0, irq}, 16'h0000);
        hread(12'h400, d); chk("R10 status", d, 16'h0000);
        hread(12'h402, d); chk("R10 length", d, 16'h0000);
        qread(d);          chk("R10 isq", d, 16'h0000);
        hread(12'h300, d); chk("R1 unmapped", d, 16'h0000);
    endtask

    task automatic t_keep_crc();
        logic [15:0] d;
        cfg_keep_crc = 1'b1;
        send_frame(64, 3, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        chk("R7 irq up", {15'd0, irq}, 16'h0001);
        hread(12'h400, d); chk("R5 status", d, 16'h0104);
        hread(12'h402, d); chk("R3 length", d, 16'h0040);
        check_frame("R2 R3 data", 3, 64);
        hread(12'h405, d); chk("R1 odd addr", d, 16'h0000);
        qread(d); chk("R8 event", d, 16'h0104);
        chk("R8 irq cleared", {15'd0, irq}, 16'h0000);
        qread(d); chk("R8 empty", d, 16'h0000);
    endtask

    task automatic t_drop_crc();
        logic [15:0] d;
        cfg_keep_crc = 1'b0;
        send_frame(21, 11, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        hread(12'h402, d); chk("R4 length", d, 16'd17);
        check_frame("R4 data", 11, 17);
        qread(d); chk("R4 event", d, 16'h0104);
    endtask

    task automatic expect_unchanged(input string req);
        logic [15:0] d;
        chk({req, " irq"}, {15'd0, irq}, 16'h0000);
        hread(12'h400, d); chk({req, " status"}, d, 16'h0104);
        hread(12'h402, d); chk({req, " length"}, d, 16'd17);
        hread(12'h404, d); chk({req, " data"}, d, {pat(11, 1), pat(11, 0)});
        qread(d); chk({req, " event"}, d, 16'h0000);
    endtask

    task automatic t_reject();
        send_frame(30, 50, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000);
        expect_unchanged("R6 bad crc");
        send_frame(30, 60, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
        expect_unchanged("R6 bad length");
        cfg_accept_ok = 1'b0;
        send_frame(30, 70, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        expect_unchanged("R5 R6 accept off");
        cfg_accept_ok = 1'b1;
        send_frame(MAXB + 2, 80, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        expect_unchanged("R6 oversize");
        send_frame(3, 85, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        expect_unchanged("R6 short");
    endtask

    task automatic t_no_irq();
        logic [15:0] d;
        cfg_irq_en = 1'b0;
        cfg_keep_crc = 1'b1;
        send_frame(8, 90, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        chk("R7 irq disabled", {15'd0, irq}, 16'h0000);
        hread(12'h402, d); chk("R7 length", d, 16'd8);
        qread(d); chk("R7 event queued", d, 16'h0104);
        cfg_irq_en = 1'b1;
    endtask

    task automatic t_collide();
        logic [15:0] d;
        send_frame(10, 100, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
        send_frame(12, 120, 1'b1, 1'b1, 1'b1, 1'b1, 12'h402);
        chk("R9 old event", isq_data, 16'h0104);
        chk("R9 old length", host_rdata, 16'd10);
        chk("R9 irq kept", {15'd0, irq}, 16'h0001);
        hread(12'h402, d); chk("R9 new length", d, 16'd12);
        check_frame("R9 new data", 120, 12);
        qread(d); chk("R9 new event", d, 16'h0104);
        qread(d); chk("R9 drained", d, 16'h0000);
        send_frame(14, 140, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
        chk("R9 empty before", isq_data, 16'h0000);
        chk("R9 irq set", {15'd0, irq}, 16'h0001);
        qread(d); chk("R9 pending after", d, 16'h0104);
        chk("R9 irq off", {15'd0, irq}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keep_crc();
        t_drop_crc();
        t_reject();
        t_no_irq();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule